// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Gating

This block turns an asynchronous serial line into characters for a receive queue. It runs on the system clock and advances only on a 16x oversampling enable. It accepts 5 to 8 data bits, sent least significant bit first, followed by an optional parity bit. For each character it reports the data, a parity error flag and a framing error flag, and it raises a one-cycle write strobe toward the receive queue.

A break is an all-zero character whose stop position is also low. The block writes one queue entry for a break and then locks. While it is locked it writes nothing, and it stays locked until the line has been high for half a bit period. A change-of-break pulse fires when a break is detected and again when the break ends, and interrupt logic can use it.

The receiver samples only the first stop bit. Any extra stop time the sender adds looks like idle line to this block.

Top module: `sio_receiver`

## Requirements
- R1: A falling edge starts a character only if the line is still low at the 8th tick after the edge. A low pulse shorter than that returns the receiver to idle and writes nothing.
- R2: Data bits are sampled 16 ticks apart, first bit to bit 0 of `rx_data`. `cfg_len` selects the length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 bits. Data bits above the configured length read as 0.
- R3: With `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity. `rx_par_err` = 1 when the XOR of the data and parity bits is 1 for even parity, or 0 for odd parity. With parity disabled, `rx_par_err` is 0.
- R4: Only one stop sample is taken, 16 ticks after the last data or parity sample. If that sample is low, `rx_frm_err` = 1. A following start bit may begin right after one stop bit time.
- R5: A character with all data bits 0, a parity bit of 0 if parity is enabled, and a low stop sample is a break. It is written once, with `rx_brk` = 1, `rx_data` = 0, `rx_frm_err` = 1 and `rx_par_err` = 0.
- R6: After a break write, no further writes occur until the line has been high for 8 consecutive ticks. A shorter high interval does not end the lock.
- R7: `brk_chg` pulses for one cycle in the cycle of the break write, and again when the lock ends.
- R8: After reset all outputs are 0.
- R9: `rx_wr` is a single-cycle pulse per character. Output flags and data are valid in the cycle `rx_wr` is high.
- R10: A break that begins partway through a character first produces that character, with a framing error and `rx_brk` = 0. It is reported as a break only at the end of the following all-zero character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, high when idle |
| cfg_len | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity error for the written character |
| rx_frm_err | output | 1 | Stop sample was low |
| rx_brk | output | 1 | Written entry is a break |
| rx_wr | output | 1 | Write strobe toward the receive queue |
| brk_chg | output | 1 | Pulse on break start and break end |

## Verification
The assertions assume that `tick16` is a single-cycle pulse spaced at least three clocks apart. Under that assumption the synchronizer delay is always shorter than one tick. They also assume that the configuration inputs change only while the line is idle.

The bench produces a tick every fourth clock. It holds every line level for a whole number of ticks and changes the configuration only between characters. It then sweeps every length and parity mode, injects parity and stop faults, and drives breaks: aligned, misaligned, and ended by high intervals that are too short.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
    import sio_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rx_i,
    input  logic          hold_i,
    input  logic [1:0]    len_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          perr_o,
    output logic          stop_o,
    output logic          zero_o
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] MID_M1  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          acc;
        logic          zero;
        logic          done;
        logic          stop;
        logic          perr;
    } frame_s;

    frame_s d, q;
    logic [IW-1:0] last_idx;

    assign last_idx = IW'(len_i) + IW'(4);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (!rx_i) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (q.cnt == MID_M1) begin
                        d.cnt = '0;
                        if (!rx_i) begin
                            d.st   = ST_DATA;
                            d.idx  = '0;
                            d.sh   = '0;
                            d.acc  = 1'b0;
                            d.zero = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (q.cnt == FULL_M1) begin
                        d.cnt        = '0;
                        d.sh[q.idx]  = rx_i;
                        d.acc        = q.acc ^ rx_i;
                        d.zero       = q.zero & ~rx_i;
                        if (q.idx == last_idx) d.st = par_en_i ? ST_PAR : ST_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    if (q.cnt == FULL_M1) begin
                        d.cnt  = '0;
                        d.acc  = q.acc ^ rx_i;
                        d.zero = q.zero & ~rx_i;
                        d.st   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (q.cnt == FULL_M1) begin
                        d.cnt  = '0;
                        d.done = 1'b1;
                        d.stop = rx_i;
                        d.perr = par_en_i & (q.acc ^ par_odd_i);
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (hold_i) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.stop <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign data_o = q.sh;
    assign perr_o = q.perr;
    assign stop_o = q.stop;
    assign zero_o = q.zero;

    // R1
    start_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && $past(q.st) != ST_DATA) |-> $past(q.st) == ST_START);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/sio_rx_brkgate.sv
module sio_rx_brkgate #(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rx_i,
    input  logic          done_i,
    input  logic [DW-1:0] data_i,
    input  logic          perr_i,
    input  logic          stop_i,
    input  logic          zero_i,
    output logic          hold_o,
    output logic          wr_o,
    output logic [DW-1:0] data_o,
    output logic          perr_o,
    output logic          ferr_o,
    output logic          brk_o,
    output logic          chg_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR/2 - 1);

    typedef struct packed {
        logic          lock;
        logic [CW-1:0] mcnt;
        logic          wr;
        logic          chg;
        logic          brk;
        logic          frm;
        logic          par;
        logic [DW-1:0] data;
    } gate_s;

    gate_s d, q;

    always_comb begin
        d     = q;
        d.wr  = 1'b0;
        d.chg = 1'b0;
        if (done_i) begin
            if (zero_i && !stop_i) begin
                if (!q.lock) begin
                    d.wr   = 1'b1;
                    d.brk  = 1'b1;
                    d.frm  = 1'b1;
                    d.par  = 1'b0;
                    d.data = '0;
                    d.lock = 1'b1;
                    d.chg  = 1'b1;
                    d.mcnt = '0;
                end
            end else if (!q.lock) begin
                d.wr   = 1'b1;
                d.brk  = 1'b0;
                d.frm  = ~stop_i;
                d.par  = perr_i;
                d.data = data_i;
            end
        end else if (q.lock && tick_i) begin
            if (!rx_i) begin
                d.mcnt = '0;
            end else if (q.mcnt == HALF_M1) begin
                d.lock = 1'b0;
                d.chg  = 1'b1;
                d.mcnt = '0;
            end else begin
                d.mcnt = q.mcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold_o = q.lock;
    assign wr_o   = q.wr;
    assign data_o = q.data;
    assign perr_o = q.par;
    assign ferr_o = q.frm;
    assign brk_o  = q.brk;
    assign chg_o  = q.chg;

    // R6
    lock_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> !q.wr);

    // R5
    brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr && q.brk) |-> (q.lock && q.data == '0 && q.frm && !q.par));

    // R7
    chg_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.chg |-> (q.lock != $past(q.lock)));

    // R9
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);
endmodule

// File: rtl/sio_receiver.sv
module sio_receiver #(
    parameter int OSR     = 16,
    parameter int DW      = 8,
    parameter int SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    output logic [DW-1:0] rx_data,
    output logic          rx_par_err,
    output logic          rx_frm_err,
    output logic          rx_brk,
    output logic          rx_wr,
    output logic          brk_chg
);
    logic          rx_s;
    logic          hold;
    logic          f_done, f_perr, f_stop, f_zero;
    logic [DW-1:0] f_data;

    sio_rx_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rxd),
        .sync_o  (rx_s)
    );

    sio_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick16),
        .rx_i      (rx_s),
        .hold_i    (hold),
        .len_i     (cfg_len),
        .par_en_i  (cfg_par_en),
        .par_odd_i (cfg_par_odd),
        .done_o    (f_done),
        .data_o    (f_data),
        .perr_o    (f_perr),
        .stop_o    (f_stop),
        .zero_o    (f_zero)
    );

    sio_rx_brkgate #(.OSR(OSR), .DW(DW)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick16),
        .rx_i   (rx_s),
        .done_i (f_done),
        .data_i (f_data),
        .perr_i (f_perr),
        .stop_i (f_stop),
        .zero_i (f_zero),
        .hold_o (hold),
        .wr_o   (rx_wr),
        .data_o (rx_data),
        .perr_o (rx_par_err),
        .ferr_o (rx_frm_err),
        .brk_o  (rx_brk),
        .chg_o  (brk_chg)
    );
endmodule

// File: tb/sio_receiver_bench.sv
module sio_receiver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] div = 2'd0;
    logic       tick16;
    logic [7:0] rx_data;
    logic       rx_par_err, rx_frm_err, rx_brk, rx_wr, brk_chg;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    int chg_cnt = 0;
    int long_wr = 0;
    logic prev_wr = 1'b0;
    logic [7:0] last_data = '0;
    logic last_par = 1'b0, last_frm = 1'b0, last_brk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) div <= div + 2'd1;
    assign tick16 = (div == 2'd3);

    sio_receiver u_sio_receiver (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .rx_brk(rx_brk), .rx_wr(rx_wr), .brk_chg(brk_chg)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_wr) begin
                wr_cnt++;
                last_data = rx_data;
                last_par  = rx_par_err;
                last_frm  = rx_frm_err;
                last_brk  = rx_brk;
            end
            if (rx_wr && prev_wr) long_wr++;
            if (brk_chg) chg_cnt++;
            prev_wr = rx_wr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int ticks);
        rxd = v;
        repeat (ticks * 4) @(posedge clk);
        #1;
    endtask

    task automatic send_char(input logic [7:0] dat, input int nb, input bit pen,
                             input bit podd, input bit pflip, input logic stopv,
                             input int stop_ticks);
        logic p;
        p = 1'b0;
        hold_line(1'b0, TPB);
        for (int i = 0; i < nb; i++) begin
            hold_line(dat[i], TPB);
            p = p ^ dat[i];
        end
        if (pen) hold_line(p ^ podd ^ pflip, TPB);
        hold_line(stopv, stop_ticks);
    endtask

    task automatic expect_char(input string req, input int w0, input logic [7:0] ed,
                               input logic ep, input logic ef, input logic eb);
        chk(wr_cnt == w0 + 1, req, wr_cnt, w0 + 1);
        chk(last_data == ed, req, last_data, ed);
        chk(last_par == ep, req, last_par, ep);
        chk(last_frm == ef, req, last_frm, ef);
        chk(last_brk == eb, req, last_brk, eb);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int w0, c0, nb;
        logic [7:0] dv, mask, ed;
        logic ep;
        repeat (5) @(posedge clk);
        #1;
        // R8 reset state
        chk({rx_data, rx_par_err, rx_frm_err, rx_brk, rx_wr, brk_chg} == 0, "R8",
            {rx_data, rx_par_err, rx_frm_err, rx_brk, rx_wr, brk_chg}, 0);
        rst_n = 1'b1;
        hold_line(1'b1, 4);

        // R2 R3 sweep over lengths, parity modes and data patterns
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 8; k++) begin
                    cfg_len = 2'(len);
                    cfg_par_en = (pm != 0);
                    cfg_par_odd = (pm == 2);
                    nb = 5 + len;
                    mask = 8'((1 << nb) - 1);
                    dv = (k == 7) ? 8'hFF : 8'(k * 37 + 3 * len + 1);
                    ed = dv & mask;
                    w0 = wr_cnt;
                    send_char(dv, nb, cfg_par_en, cfg_par_odd, 1'b0, 1'b1, TPB);
                    expect_char("R2", w0, ed, 1'b0, 1'b0, 1'b0);
                    hold_line(1'b1, 2);
                end
                if (pm != 0) begin
                    // R3 injected parity fault
                    w0 = wr_cnt;
                    ed = 8'(8'h5A & ((1 << nb) - 1));
                    send_char(8'h5A, nb, 1'b1, cfg_par_odd, 1'b1, 1'b1, TPB);
                    expect_char("R3", w0, ed, 1'b1, 1'b0, 1'b0);
                    hold_line(1'b1, 2);
                end
            end
        end

        // R4 framing fault with parity enabled
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        w0 = wr_cnt;
        send_char(8'h81, 8, 1'b1, 1'b0, 1'b0, 1'b0, TPB);
        hold_line(1'b1, 20);
        ep = 1'b0;
        expect_char("R4", w0, 8'h81, ep, 1'b1, 1'b0);

        // R4 back-to-back characters with a single stop bit
        cfg_par_en = 1'b0;
        w0 = wr_cnt;
        send_char(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1, TPB);
        send_char(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b1, TPB);
        chk(wr_cnt == w0 + 2, "R4", wr_cnt, w0 + 2);
        chk(last_data == 8'hC3 && !last_frm, "R4", {last_frm, last_data}, 8'hC3);
        hold_line(1'b1, 4);

        // R1 glitch shorter than half a bit
        w0 = wr_cnt;
        hold_line(1'b0, 4);
        hold_line(1'b1, 40);
        chk(wr_cnt == w0, "R1", wr_cnt, w0);

        // R5 R7 aligned break
        w0 = wr_cnt; c0 = chg_cnt;
        hold_line(1'b0, 16 * 30);
        expect_char("R5", w0, 8'h00, 1'b0, 1'b1, 1'b1);
        chk(chg_cnt == c0 + 1, "R7", chg_cnt, c0 + 1);
        // R6 short mark does not end the lock
        hold_line(1'b1, 4);
        hold_line(1'b0, 40);
        chk(wr_cnt == w0 + 1, "R6", wr_cnt, w0 + 1);
        chk(chg_cnt == c0 + 1, "R6", chg_cnt, c0 + 1);
        // R6 R7 half-bit mark ends the lock
        hold_line(1'b1, 12);
        chk(chg_cnt == c0 + 2, "R7", chg_cnt, c0 + 2);
        w0 = wr_cnt;
        send_char(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1, TPB);
        expect_char("R6", w0, 8'h96, 1'b0, 1'b0, 1'b0);
        hold_line(1'b1, 4);

        // R5 break with parity enabled, 5-bit length
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        w0 = wr_cnt; c0 = chg_cnt;
        hold_line(1'b0, 16 * 20);
        expect_char("R5", w0, 8'h00, 1'b0, 1'b1, 1'b1);
        hold_line(1'b1, 12);
        chk(chg_cnt == c0 + 2, "R7", chg_cnt, c0 + 2);

        // R10 break starting mid-character
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        w0 = wr_cnt; c0 = chg_cnt;
        hold_line(1'b0, TPB);
        hold_line(1'b1, 3 * TPB);
        hold_line(1'b0, 7 * TPB);
        expect_char("R10", w0, 8'h07, 1'b0, 1'b1, 1'b0);
        chk(chg_cnt == c0, "R10", chg_cnt, c0);
        hold_line(1'b0, 12 * TPB);
        expect_char("R10", w0 + 1, 8'h00, 1'b0, 1'b1, 1'b1);
        hold_line(1'b1, 12);
        chk(chg_cnt == c0 + 2, "R7", chg_cnt, c0 + 2);

        // R9 every write strobe was one cycle wide
        chk(long_wr == 0, "R9", long_wr, 0);

        summary();
        $finish;
    end
endmodule